// File: doc/BRIEF.md
# Watchdog Control Register Unit

This block holds the control register of a watchdog timer and decides when the watchdog's time-out period starts over. The register has three fields: a window-mode flag, a keep-running-in-background flag, and a 3-bit rate select. Software writes the register through a plain write port. A mask bit in the write data stops the window flag and the rate select from being updated by that write. What a write may change depends on the operating mode. In special mode the fields can be written any number of times. In normal mode the window flag and the rate select accept a single unmasked write after reset, and the background flag can only be set.

At the end of reset the fields take their values from a parallel initial-value input. If the initial rate is non-zero, the time-out starts at once. The unit also watches the watchdog clock-select bits and the oscillator status, and restarts the time-out on the events that call for it. It produces a run/halt enable for the counter, which depends on stop mode, pseudo-stop, the clock-select bits and a keep-clock enable. A small down-counter with a rate decoder is built in, so that restarts and time-outs can be seen at the ports.

Top module: `wdog_ctl_unit`

## Requirements
- R1: `rd_data` shows the register: bit 7 is the window flag, bit 6 is the background flag, bits 5:3 read as 0, and bits 2:0 are the rate select.
- R2: While `rst` is high, the fields load `init_window`, `init_bg_stop` and `init_rate`. In the first cycle after release, `restart` pulses exactly when the loaded rate is non-zero.
- R3: A write with bit 5 = 1 leaves the window flag and the rate select unchanged, and does not use up the normal-mode single write.
- R4: In normal mode only the first write after reset with bit 5 = 0 can change the window flag or the rate select. Every later such write is ignored.
- R5: A write with rate bits 000 leaves the rate unchanged, and a write with bit 7 = 0 leaves the window flag unchanged. Such a write still uses up the normal-mode single write.
- R6: In special mode every write with bit 5 = 0 updates the window flag and the rate select (subject to R5), and bit 6 writes the background flag to either 0 or 1.
- R7: In normal mode, writing bit 6 = 1 sets the background flag and writing bit 6 = 0 leaves it unchanged.
- R8: In normal mode, `restart` pulses for one cycle, in the cycle after the write, when any of these is written: an accepted non-zero rate, an accepted window bit of 1, or a background bit that changes it from 0 to 1.
- R9: In special mode every write access, of any value, produces a `restart` pulse in the next cycle.
- R10: `restart` pulses in the cycle after `clk_sel` changes value. It also pulses in the cycle after `osc_ok` falls while `clk_sel` = 01.
- R11: `cnt_run` follows one cycle later the value of (not stop) or `clk_sel[1]` or (`pseudo_stop` and `clk_sel[0]` and `stop_keep_en`).
- R12: With rate r non-zero and `cnt_run` high, `timeout` pulses for one cycle, 2^(BASE_EXP+EXP_STEP·r)+1 cycles after `restart` is seen high. With rate 0, or with the counter halted, no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bit 5 is the update mask |
| rd_data | output | 8 | Register read value |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| stop_mode | input | 1 | System is in stop mode |
| pseudo_stop | input | 1 | Stop mode is the pseudo variant |
| stop_keep_en | input | 1 | Keep the oscillator clock running in stop |
| clk_sel | input | 2 | Watchdog clock-select bits |
| osc_ok | input | 1 | Oscillator status good |
| init_window | input | 1 | Initial value of the window flag |
| init_bg_stop | input | 1 | Initial value of the background flag |
| init_rate | input | 3 | Initial value of the rate select |
| window_mode | output | 1 | Window flag |
| bg_stop | output | 1 | Background flag |
| rate_sel | output | 3 | Rate select |
| restart | output | 1 | One-cycle time-out restart pulse |
| cnt_run | output | 1 | Counter run enable |
| timeout | output | 1 | One-cycle time-out pulse |

## Verification
The hardest state to reach is a normal-mode write that arrives after the single write has already been used. This matters most when the earlier write was a masked write, which does not use it up, or a zero-value write, which does. Directed sequences build these orderings on purpose right after reset. A long random phase then switches modes and mixes masked and unmasked writes, so that the used-up state is met from many histories. The time-out length is measured directly with reduced rate parameters, and halting is shown by holding stop mode through more than one full period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W   = 8;
  localparam int CR_W     = 3;
  localparam int BIT_WIN  = 7;
  localparam int BIT_BG   = 6;
  localparam int BIT_MASK = 5;
  localparam int SEL_W    = 2;

  typedef struct packed {
    logic            win;
    logic            bg;
    logic [CR_W-1:0] rate;
  } wdog_fields_t;
endpackage

// File: rtl/wdog_reg.sv
module wdog_reg
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_win,
  input  logic            wr_bg,
  input  logic            wr_mask,
  input  logic [CR_W-1:0] wr_rate,
  input  logic            special_mode,
  input  wdog_fields_t    init_val,
  output wdog_fields_t    fld_q,
  output logic            fld_restart,
  output logic            bg_rise
);
  logic used_q;
  logic fld_ok;

  assign fld_ok      = wr_en && !wr_mask && (special_mode || !used_q);
  assign fld_restart = fld_ok && (wr_win || (wr_rate != '0));
  assign bg_rise     = wr_en && wr_bg && !fld_q.bg;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q  <= init_val;
      used_q <= 1'b0;
    end else if (wr_en) begin
      if (fld_ok) begin
        if (wr_win) fld_q.win <= 1'b1;
        if (wr_rate != '0) fld_q.rate <= wr_rate;
        if (!special_mode) used_q <= 1'b1;
      end
      if (special_mode) fld_q.bg <= wr_bg;
      else if (wr_bg) fld_q.bg <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_restart.sv
module wdog_restart
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             special_mode,
  input  logic             fld_restart,
  input  logic             bg_rise,
  input  logic [CR_W-1:0]  rate,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             osc_ok,
  input  logic             stop_mode,
  input  logic             pseudo_stop,
  input  logic             stop_keep_en,
  output logic             restart_q,
  output logic             run_q
);
  logic             boot_q;
  logic [SEL_W-1:0] sel_prev_q;
  logic             osc_prev_q;
  logic             ev_boot, ev_write, ev_sel, ev_osc, run_c;

  assign ev_boot  = boot_q && (rate != '0);
  assign ev_write = special_mode ? wr_en : (fld_restart || bg_rise);
  assign ev_sel   = (clk_sel != sel_prev_q);
  assign ev_osc   = osc_prev_q && !osc_ok && !clk_sel[1] && clk_sel[0];
  assign run_c    = !stop_mode || clk_sel[1] ||
                    (pseudo_stop && clk_sel[0] && stop_keep_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q     <= 1'b1;
      sel_prev_q <= clk_sel;
      osc_prev_q <= osc_ok;
      restart_q  <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      boot_q     <= 1'b0;
      sel_prev_q <= clk_sel;
      osc_prev_q <= osc_ok;
      restart_q  <= ev_boot || ev_write || ev_sel || ev_osc;
      run_q      <= run_c;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 12,
  parameter int EXP_STEP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            run,
  input  logic [CR_W-1:0] rate,
  output logic            timeout_q
);
  localparam int MAX_EXP = BASE_EXP + EXP_STEP * ((1 << CR_W) - 1);
  localparam int CNT_W   = MAX_EXP + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    if (rate == '0) load_val = '0;
    else load_val = CNT_W'(1) << (BASE_EXP + EXP_STEP * int'(rate));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      timeout_q <= 1'b0;
      if (restart) begin
        cnt_q <= load_val;
      end else if (run && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) timeout_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_ctl_unit.sv
module wdog_ctl_unit
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 12,
  parameter int EXP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic             special_mode,
  input  logic             stop_mode,
  input  logic             pseudo_stop,
  input  logic             stop_keep_en,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             osc_ok,
  input  logic             init_window,
  input  logic             init_bg_stop,
  input  logic [CR_W-1:0]  init_rate,
  output logic             window_mode,
  output logic             bg_stop,
  output logic [CR_W-1:0]  rate_sel,
  output logic             restart,
  output logic             cnt_run,
  output logic             timeout
);
  wdog_fields_t init_val, fld;
  logic         fld_restart, bg_rise;
  logic         unused_bits;

  assign init_val    = '{win: init_window, bg: init_bg_stop, rate: init_rate};
  assign unused_bits = ^wr_data[BIT_MASK-1:CR_W];

  wdog_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_win      (wr_data[BIT_WIN]),
    .wr_bg       (wr_data[BIT_BG]),
    .wr_mask     (wr_data[BIT_MASK]),
    .wr_rate     (wr_data[CR_W-1:0]),
    .special_mode(special_mode),
    .init_val    (init_val),
    .fld_q       (fld),
    .fld_restart (fld_restart),
    .bg_rise     (bg_rise)
  );

  wdog_restart u_rst (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .special_mode(special_mode),
    .fld_restart (fld_restart),
    .bg_rise     (bg_rise),
    .rate        (fld.rate),
    .clk_sel     (clk_sel),
    .osc_ok      (osc_ok),
    .stop_mode   (stop_mode),
    .pseudo_stop (pseudo_stop),
    .stop_keep_en(stop_keep_en),
    .restart_q   (restart),
    .run_q       (cnt_run)
  );

  wdog_count #(.BASE_EXP(BASE_EXP), .EXP_STEP(EXP_STEP)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .run      (cnt_run),
    .rate     (fld.rate),
    .timeout_q(timeout)
  );

  assign window_mode = fld.win;
  assign bg_stop     = fld.bg;
  assign rate_sel    = fld.rate;
  assign rd_data     = {fld.win, fld.bg, {(BIT_BG-CR_W){1'b0}}, fld.rate};
endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              special_mode,
  input logic [SEL_W-1:0]  clk_sel,
  input logic              osc_ok,
  input logic              window_mode,
  input logic              bg_stop,
  input logic [CR_W-1:0]   rate_sel,
  input logic              restart,
  input logic              timeout
);
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[BIT_MASK] |=> $stable(rate_sel) && $stable(window_mode)); // R3

  AST_BG_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_en && !special_mode && bg_stop |=> bg_stop); // R7

  AST_SPECIAL_RESTART: assert property (@(posedge clk) disable iff (rst)
    wr_en && special_mode |=> restart); // R9

  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (rst)
    clk_sel != $past(clk_sel) |=> restart); // R10

  AST_OSC_RESTART: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_ok) && clk_sel == 2'b01 |=> restart); // R10

  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout); // R12

  AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (rst)
    rate_sel == '0 |-> !timeout); // R12
endmodule

bind wdog_ctl_unit wdog_ctl_chk u_chk (.*);

// File: tb/sim_wdog_ctl_unit.sv
`timescale 1ns/100ps
module sim_wdog_ctl_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       special_mode = 1'b0, stop_mode = 1'b0, pseudo_stop = 1'b0, stop_keep_en = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic       osc_ok = 1'b1;
  logic       init_window = 1'b0, init_bg_stop = 1'b0;
  logic [2:0] init_rate = 3'd0;
  logic       window_mode, bg_stop, restart, cnt_run, timeout;
  logic [2:0] rate_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  logic       m_win, m_bg, m_used, m_boot, m_prev_osc, e_restart, e_run;
  logic [2:0] m_rate;
  logic [1:0] m_prev_sel;

  always #2.5 clk = ~clk;

  wdog_ctl_unit #(.BASE_EXP(2), .EXP_STEP(1)) u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic ev, acc;
    @(posedge clk);
    if (rst) begin
      m_win = init_window; m_bg = init_bg_stop; m_rate = init_rate;
      m_used = 0; m_boot = 1; m_prev_sel = clk_sel; m_prev_osc = osc_ok;
      e_restart = 0; e_run = 0;
    end else begin
      ev = (m_boot && m_rate != 0);
      m_boot = 0;
      if (clk_sel != m_prev_sel) ev = 1;
      if (m_prev_osc && !osc_ok && clk_sel == 2'b01) ev = 1;
      if (wr_en) begin
        acc = !wr_data[5] && (special_mode || !m_used);
        if (special_mode) ev = 1;
        else begin
          if (acc && (wr_data[7] || wr_data[2:0] != 0)) ev = 1;
          if (wr_data[6] && !m_bg) ev = 1;
        end
        if (acc) begin
          if (wr_data[7]) m_win = 1;
          if (wr_data[2:0] != 0) m_rate = wr_data[2:0];
          if (!special_mode) m_used = 1;
        end
        if (special_mode) m_bg = wr_data[6];
        else if (wr_data[6]) m_bg = 1;
      end
      m_prev_sel = clk_sel; m_prev_osc = osc_ok;
      e_restart = ev;
      e_run = !stop_mode || clk_sel[1] || (pseudo_stop && clk_sel[0] && stop_keep_en);
    end
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    check({tag, " R1 rd_data"}, rd_data, {m_win, m_bg, 3'b000, m_rate});
    check({tag, " R1 window"}, window_mode, m_win);
    check({tag, " R1 bg"}, bg_stop, m_bg);
    check({tag, " R1 rate"}, rate_sel, m_rate);
    check({tag, " R8 restart"}, restart, e_restart);
    check({tag, " R11 run"}, cnt_run, e_run);
  endtask

  task automatic do_reset(logic w, logic b, logic [2:0] r);
    rst = 1; wr_en = 0; init_window = w; init_bg_stop = b; init_rate = r;
    step(); step();
    rst = 0;
    step();
  endtask

  task automatic wr(logic [7:0] d, string tag);
    wr_en = 1; wr_data = d;
    step();
    wr_en = 0;
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    // R2 and R12: initial rate 1, timeout after 2^3 + 1 samples
    do_reset(1'b0, 1'b0, 3'd1);
    check("R2 boot restart", restart, 1);
    check_all("R2");
    n = 0;
    while (n < 100) begin step(); n++; if (timeout) break; end
    check("R12 timeout distance", n, 9);
    step();
    check("R12 one-cycle pulse", timeout, 0);

    // Normal mode write-once sequence
    wr(8'hA7, "R3 masked");
    check("R3 rate held", rate_sel, 1);
    wr(8'h00, "R5 zero write");
    check("R5 rate held", rate_sel, 1);
    check("R5 no restart", restart, 0);
    wr(8'h83, "R4 second write");
    check("R4 window ignored", window_mode, 0);
    check("R4 rate ignored", rate_sel, 1);
    wr(8'h40, "R7 set bg");
    check("R8 bg rise restart", restart, 1);
    check("R7 bg set", bg_stop, 1);
    wr(8'h00, "R7 clear attempt");
    check("R7 bg kept", bg_stop, 1);

    // Special mode
    special_mode = 1;
    wr(8'h00, "R9 special");
    check("R9 restart", restart, 1);
    check("R6 bg cleared", bg_stop, 0);
    wr(8'h82, "R6 special");
    check("R6 rate", rate_sel, 2);
    check("R6 window", window_mode, 1);
    wr(8'h04, "R6 special again");
    check("R6 rate again", rate_sel, 4);
    special_mode = 0;

    // Clock select and oscillator
    clk_sel = 2'b01; step(); check("R10 sel change", restart, 1);
    step(); check("R10 quiet", restart, 0);
    osc_ok = 0; step(); check("R10 osc loss", restart, 1);
    osc_ok = 1; step(); check_all("R10");

    // Halt in stop mode
    clk_sel = 2'b00; stop_mode = 1;
    do_reset(1'b0, 1'b0, 3'd1);
    step();
    check("R11 halted", cnt_run, 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin step(); if (timeout) n++; end
    check("R11 no timeout when halted", n, 0);
    pseudo_stop = 1; stop_keep_en = 1; clk_sel = 2'b01;
    step(); step();
    check("R11 pseudo keep runs", cnt_run, 1);
    stop_mode = 0; pseudo_stop = 0; stop_keep_en = 0; clk_sel = 2'b00;

    // Rate 0: no boot restart, no timeout
    do_reset(1'b0, 1'b0, 3'd0);
    check("R2 no boot restart", restart, 0);
    n = 0;
    for (int i = 0; i < 60; i++) begin step(); if (timeout) n++; end
    check("R12 rate0 quiet", n, 0);

    // Constrained random phase
    void'($urandom(32'h5eed1234));
    do_reset(1'($urandom), 1'($urandom), 3'($urandom));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        do_reset(1'($urandom), 1'($urandom), 3'($urandom));
        continue;
      end
      if ($urandom_range(0, 49) == 0) special_mode = ~special_mode;
      wr_en = ($urandom_range(0, 9) < 3);
      wr_data = 8'($urandom);
      if ($urandom_range(0, 29) == 0) clk_sel = 2'($urandom);
      if ($urandom_range(0, 9) == 0) osc_ok = ~osc_ok;
      stop_mode = 1'($urandom); pseudo_stop = 1'($urandom); stop_keep_en = 1'($urandom);
      step();
      check_all("random");
    end
    wr_en = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule